// File: doc/BRIEF.md
# Slot Power and Reset Sequencer

This block controls one hot-pluggable slot. It drives the slot's power-enable output and the slot's active-low reset output, and it keeps the order and spacing of their edges as slot power is switched on or off. A control bit requests the slot power state: a one asks for power off and a zero asks for power on. Two programmable gap fields set how long each edge waits for the edge before it. A hardware timer makes every reset pulse last at least a minimum time, whatever values the gap fields hold.

The reset output works in one of two modes. In power-enable mode the sequencer switches power on and then releases reset. When switching off, it asserts reset and then removes power. In power-good mode the reset output follows a power-good input, which is first synchronised to the block's clock. A separate configuration input states whether the pin is used as a reset output. Until it is, the pin's output enable stays low, so the pin stays tri-stated.

All timing counts in ticks of a prescaler. One tick lasts `TICK_CLKS = CLK_HZ / TICK_HZ` clocks. The minimum reset width is `MIN_TICKS = ceil(MIN_RST_US * TICK_HZ / 1e6)` ticks, which is 200 by default. Each timer restarts its prescaler when it is armed, so every gap is a whole number of clocks that can be predicted.

Top module: `slot_pwr_rst_seq`

## Requirements
- R1: While `rst` is high, and after its release until sequencing starts, `slot_pwr_en` is 0, `slot_rst_n` is 0 and `slot_rst_oe` is 0.
- R2: In power-enable mode (`rst_mode` = 0), `slot_rst_n` is 0 in every cycle in which `slot_pwr_en` is 0.
- R3: In power-enable mode, a power-on request (`pwr_off_req` = 0) raises `slot_pwr_en` first. Provided the minimum reset width has elapsed, `slot_rst_n` rises `dly_pwr2rst * TICK_CLKS + 1` clocks after `slot_pwr_en` rises.
- R4: In power-enable mode, a power-off request (`pwr_off_req` = 1) from the on state lowers `slot_rst_n` on the first clock edge that samples it. `slot_pwr_en` then falls `dly_rst2pwr * TICK_CLKS + 1` clocks after `slot_rst_n` falls.
- R5: In power-enable mode, once power-on has completed and no power-off is requested, `slot_pwr_en` stays 1 and `slot_rst_n` stays 1.
- R6: Each low period of `slot_rst_n` lasts at least `MIN_TICKS * TICK_CLKS + 1` clocks, counted from the clock edge that asserted it. Release from `rst` counts as an assertion.
- R7: A power-on request made while a power-off gap is running does not shorten that gap. Power-on starts only after `slot_pwr_en` has fallen and the minimum reset width has elapsed, that is `MIN_TICKS * TICK_CLKS + 1` clocks after `slot_rst_n` fell.
- R8: In power-good mode (`rst_mode` = 1), `slot_pwr_en` equals the inverse of `pwr_off_req` one clock later. `slot_rst_n` falls `PGOOD_SYNC + 1` clocks after `pgood_in` goes low. It rises `PGOOD_SYNC + 1` clocks after `pgood_in` goes high, but never before the minimum width of R6 has elapsed.
- R9: `slot_rst_oe` equals `cfg_rst_out_en` delayed by one clock. Its value has no effect on `slot_rst_n`.
- R10: A power-off request that arrives during the power-on gap abandons power-on. `slot_rst_n` stays 0, and `slot_pwr_en` falls `dly_rst2pwr * TICK_CLKS + 1` clocks after the edge that sampled the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rst_out_en | input | 1 | Pin configured as reset output (drives output enable) |
| rst_mode | input | 1 | 0 = power-enable controlled, 1 = power-good controlled |
| pwr_off_req | input | 1 | 1 = request slot power off, 0 = request power on |
| dly_pwr2rst | input | DLY_W | Ticks from power-enable assertion to reset negation |
| dly_rst2pwr | input | DLY_W | Ticks from reset assertion to power-enable negation |
| pgood_in | input | 1 | Slot power-good, asynchronous |
| slot_pwr_en | output | 1 | Slot power enable, active high |
| slot_rst_n | output | 1 | Slot reset, active low |
| slot_rst_oe | output | 1 | Output enable of the reset pin |

## Verification
The bench measures the spacing between the two output edges for several pairs of gap values, including zero. A design that restarted its prescaler in the wrong place, or that mixed up the two gap fields, would show gaps that differ by one clock or by whole ticks. Directed cases go after the minimum width. In one case a power-on follows a zero-gap power-off at once. In another a power-on request arrives in the middle of a long power-off gap. In a third, power-good drops and recovers at once. A design without the width floor would release reset after a few clocks, and one that restarted power-on early would raise power-enable inside the gap. An abort during the power-on gap checks that reset never pulses high on the way down.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_PWR_UP = 2'd1,
    ST_ON     = 2'd2,
    ST_PWR_DN = 2'd3
  } seq_state_e;

  typedef enum logic {
    MODE_PWR_EN   = 1'b0,
    MODE_PWR_GOOD = 1'b1
  } rst_mode_e;

endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign d_out = d_in;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) begin
          chain <= '0;
        end else begin
          chain[0] <= d_in;
          for (int i = 1; i < STAGES; i++) begin
            chain[i] <= chain[i-1];
          end
        end
      end
      assign d_out = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/seq_tick_timer.sv
module seq_tick_timer #(
  parameter int   TICK_CLKS  = 125,
  parameter int   CNT_W      = 8,
  parameter logic RESET_BUSY = 1'b0,
  parameter int   RESET_LOAD = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             busy
);

  localparam int PRE_W = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CLKS - 1);

  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= RESET_BUSY;
      cnt  <= CNT_W'(RESET_LOAD);
      pre  <= '0;
    end else if (start) begin
      pre  <= '0;
      cnt  <= load;
      busy <= (load != '0);
    end else if (busy) begin
      if (pre == PRE_LAST) begin
        pre <= '0;
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
        end
      end else begin
        pre <= pre + PRE_W'(1);
      end
    end
  end

  AST_TMR_LIVE_COUNT: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt != '0)); // R6

  AST_TMR_ARMS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (start && load != '0) |=> (busy && cnt == $past(load))); // R3

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import slot_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mode,
  input  logic pwr_off_req,
  input  logic pgood,
  input  logic gap_done,
  input  logic min_done,
  output logic gap_start,
  output logic gap_sel_off,
  output logic min_start,
  output logic pwr_en,
  output logic rst_asrt
);

  seq_state_e st, st_n;
  logic       pwr_n, asrt_n;
  rst_mode_e  mode_e;

  assign mode_e = rst_mode_e'(mode);

  always_comb begin
    st_n        = st;
    pwr_n       = pwr_en;
    asrt_n      = rst_asrt;
    gap_start   = 1'b0;
    gap_sel_off = 1'b0;
    min_start   = 1'b0;
    if (mode_e == MODE_PWR_GOOD) begin
      st_n  = ST_OFF;
      pwr_n = !pwr_off_req;
      if (!rst_asrt && !pgood) begin
        asrt_n    = 1'b1;
        min_start = 1'b1;
      end else if (rst_asrt && pgood && min_done) begin
        asrt_n = 1'b0;
      end
    end else begin
      unique case (st)
        ST_OFF: begin
          if (!rst_asrt) begin
            asrt_n    = 1'b1;
            min_start = 1'b1;
          end else if (pwr_en) begin
            pwr_n = 1'b0;
          end else if (!pwr_off_req && min_done) begin
            st_n      = ST_PWR_UP;
            pwr_n     = 1'b1;
            gap_start = 1'b1;
          end
        end
        ST_PWR_UP: begin
          if (pwr_off_req) begin
            st_n        = ST_PWR_DN;
            gap_start   = 1'b1;
            gap_sel_off = 1'b1;
          end else if (gap_done && min_done) begin
            st_n   = ST_ON;
            asrt_n = 1'b0;
          end
        end
        ST_ON: begin
          if (pwr_off_req) begin
            st_n        = ST_PWR_DN;
            asrt_n      = 1'b1;
            min_start   = 1'b1;
            gap_start   = 1'b1;
            gap_sel_off = 1'b1;
          end
        end
        ST_PWR_DN: begin
          if (gap_done) begin
            st_n  = ST_OFF;
            pwr_n = 1'b0;
          end
        end
        default: st_n = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_OFF;
      pwr_en   <= 1'b0;
      rst_asrt <= 1'b1;
    end else begin
      st       <= st_n;
      pwr_en   <= pwr_n;
      rst_asrt <= asrt_n;
    end
  end

  AST_PWR_ON_ORDER: assert property (@(posedge clk) disable iff (rst)
    ($rose(pwr_en) && mode == MODE_PWR_EN) |-> (rst_asrt && $past(rst_asrt))); // R3

  AST_RST_NEG_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
    ($fell(rst_asrt) && mode == MODE_PWR_EN && $past(mode) == MODE_PWR_EN)
      |-> ($past(gap_done) && pwr_en)); // R3

  AST_PWR_OFF_ORDER: assert property (@(posedge clk) disable iff (rst)
    ($fell(pwr_en) && mode == MODE_PWR_EN) |-> $past(rst_asrt)); // R4

  AST_OFF_HOLDS_RST: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_PWR_EN && $past(mode) == MODE_PWR_EN && !pwr_en) |-> rst_asrt); // R2

  AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_asrt) |-> $past(min_done)); // R6

  AST_PG_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_PWR_GOOD && $past(mode) == MODE_PWR_GOOD && !$past(rst_asrt) && !$past(pgood))
      |-> rst_asrt); // R8

endmodule

// File: rtl/slot_pwr_rst_seq.sv
module slot_pwr_rst_seq #(
  parameter int CLK_HZ     = 125_000_000,
  parameter int TICK_HZ    = 1_000_000,
  parameter int MIN_RST_US = 200,
  parameter int DLY_W      = 8,
  parameter int PGOOD_SYNC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_rst_out_en,
  input  logic             rst_mode,
  input  logic             pwr_off_req,
  input  logic [DLY_W-1:0] dly_pwr2rst,
  input  logic [DLY_W-1:0] dly_rst2pwr,
  input  logic             pgood_in,
  output logic             slot_pwr_en,
  output logic             slot_rst_n,
  output logic             slot_rst_oe
);

  localparam int TICK_CLKS = CLK_HZ / TICK_HZ;
  localparam int MIN_TICKS =
    int'((longint'(MIN_RST_US) * longint'(TICK_HZ) + 64'd999_999) / 64'd1_000_000);
  localparam int MIN_W = $clog2(MIN_TICKS + 1);

  logic             pgood_s;
  logic             gap_start, gap_sel_off, gap_busy;
  logic             min_start, min_busy;
  logic             pwr_en_q, rst_asrt_q;
  logic [DLY_W-1:0] gap_load;

  seq_sync #(.STAGES(PGOOD_SYNC)) u_pgood_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (pgood_in),
    .d_out (pgood_s)
  );

  assign gap_load = gap_sel_off ? dly_rst2pwr : dly_pwr2rst;

  seq_tick_timer #(
    .TICK_CLKS  (TICK_CLKS),
    .CNT_W      (DLY_W),
    .RESET_BUSY (1'b0),
    .RESET_LOAD (0)
  ) u_gap_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (gap_start),
    .load  (gap_load),
    .busy  (gap_busy)
  );

  seq_tick_timer #(
    .TICK_CLKS  (TICK_CLKS),
    .CNT_W      (MIN_W),
    .RESET_BUSY (1'b1),
    .RESET_LOAD (MIN_TICKS)
  ) u_min_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (min_start),
    .load  (MIN_W'(MIN_TICKS)),
    .busy  (min_busy)
  );

  seq_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .mode        (rst_mode),
    .pwr_off_req (pwr_off_req),
    .pgood       (pgood_s),
    .gap_done    (!gap_busy),
    .min_done    (!min_busy),
    .gap_start   (gap_start),
    .gap_sel_off (gap_sel_off),
    .min_start   (min_start),
    .pwr_en      (pwr_en_q),
    .rst_asrt    (rst_asrt_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_rst_oe <= 1'b0;
    end else begin
      slot_rst_oe <= cfg_rst_out_en;
    end
  end

  assign slot_pwr_en = pwr_en_q;
  assign slot_rst_n  = !rst_asrt_q;

  AST_OE_FOLLOWS_CFG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (slot_rst_oe == $past(cfg_rst_out_en))); // R9

  AST_RESET_OUTPUTS: assert property (@(posedge clk)
    $past(rst) |-> (!slot_pwr_en && !slot_rst_n && !slot_rst_oe)); // R1

endmodule

// File: tb/slot_pwr_rst_seq_tb.sv
module slot_pwr_rst_seq_tb;

  localparam int CLK_HZ     = 8_000_000;
  localparam int TICK_HZ    = 1_000_000;
  localparam int MIN_RST_US = 200;
  localparam int DLY_W      = 8;
  localparam int PGOOD_SYNC = 2;
  localparam int TC         = CLK_HZ / TICK_HZ;
  localparam int MIN_CLKS   = (MIN_RST_US * TICK_HZ / 1_000_000) * TC;
  localparam int NVEC       = 5;
  localparam logic [7:0] VEC_UP [NVEC] = '{8'd0, 8'd1, 8'd5, 8'd20, 8'd0};
  localparam logic [7:0] VEC_DN [NVEC] = '{8'd0, 8'd3, 8'd2, 8'd0, 8'd17};

  logic             clk = 1'b0;
  logic             rst;
  logic             cfg_rst_out_en;
  logic             rst_mode;
  logic             pwr_off_req;
  logic [DLY_W-1:0] dly_pwr2rst;
  logic [DLY_W-1:0] dly_rst2pwr;
  logic             pgood_in;
  logic             slot_pwr_en, slot_rst_n, slot_rst_oe;

  always #4 clk = ~clk;

  slot_pwr_rst_seq #(
    .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .MIN_RST_US(MIN_RST_US),
    .DLY_W(DLY_W), .PGOOD_SYNC(PGOOD_SYNC)
  ) u_dut (
    .clk(clk), .rst(rst), .cfg_rst_out_en(cfg_rst_out_en), .rst_mode(rst_mode),
    .pwr_off_req(pwr_off_req), .dly_pwr2rst(dly_pwr2rst), .dly_rst2pwr(dly_rst2pwr),
    .pgood_in(pgood_in), .slot_pwr_en(slot_pwr_en), .slot_rst_n(slot_rst_n),
    .slot_rst_oe(slot_rst_oe)
  );

  int checks = 0;
  int fails  = 0;
  int cyc = 0;
  int t_pr = 0, t_pf = 0, t_rr = 0, t_rf = 0, n_rr = 0, order_bad = 0;
  logic prev_p = 1'b0, prev_r = 1'b0;

  // edge recorder, sampled on the falling clock edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (slot_pwr_en !== prev_p) begin
        if (slot_pwr_en) t_pr = cyc; else t_pf = cyc;
      end
      if (slot_rst_n !== prev_r) begin
        if (slot_rst_n) begin t_rr = cyc; n_rr++; end else t_rf = cyc;
      end
      if (rst_mode == 1'b0 && slot_pwr_en == 1'b0 && slot_rst_n == 1'b1) order_bad++;
    end
    prev_p = slot_pwr_en;
    prev_r = slot_rst_n;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_out(input bit on_rst, input logic val);
    int k = 0;
    while (((on_rst ? slot_rst_n : slot_pwr_en) !== val) && k < 20000) begin
      step();
      k++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int c, rel, nr;
    rst = 1'b1; cfg_rst_out_en = 1'b0; rst_mode = 1'b0; pwr_off_req = 1'b1;
    dly_pwr2rst = '0; dly_rst2pwr = '0; pgood_in = 1'b0;
    repeat (4) step();
    chk("R1 pwr_en in reset", slot_pwr_en, 0);
    chk("R1 rst_n in reset", slot_rst_n, 0);
    chk("R1 rst_oe in reset", slot_rst_oe, 0);
    rst = 1'b0;
    rel = cyc;

    // R9: output enable follows its config one clock later, rst_n untouched
    step();
    cfg_rst_out_en = 1'b1;
    step();
    chk("R9 oe high", slot_rst_oe, 1);
    chk("R9 rst_n unaffected", slot_rst_n, 0);
    cfg_rst_out_en = 1'b0;
    step();
    chk("R9 oe low", slot_rst_oe, 0);

    while (cyc < rel + MIN_CLKS + 20) step();
    chk("R1 rst_n held before power-on", n_rr, 0);
    chk("R1 pwr_en held before power-on", slot_pwr_en, 0);

    // table walk: on/off gaps for each delay pair
    for (int i = 0; i < NVEC; i++) begin
      dly_pwr2rst = VEC_UP[i];
      dly_rst2pwr = VEC_DN[i];
      pwr_off_req = 1'b0;
      wait_out(1'b1, 1'b1);
      chk("R3 pwr-to-rst gap", t_rr - t_pr, VEC_UP[i] * TC + 1);
      repeat (10) step();
      chk("R5 on state outputs", {slot_pwr_en, slot_rst_n}, 2'b11);
      c = cyc;
      pwr_off_req = 1'b1;
      wait_out(1'b0, 1'b0);
      chk("R4 rst falls first", t_rf - c, 1);
      chk("R4 rst-to-pwr gap", t_pf - t_rf, VEC_DN[i] * TC + 1);
      repeat (MIN_CLKS + 20) step();
      chk("R2 off state outputs", {slot_pwr_en, slot_rst_n}, 2'b00);
    end

    // R6: immediate power-on after a zero-gap power-off
    dly_pwr2rst = '0; dly_rst2pwr = '0;
    pwr_off_req = 1'b0;
    wait_out(1'b1, 1'b1);
    pwr_off_req = 1'b1;
    wait_out(1'b0, 1'b0);
    repeat (3) step();
    pwr_off_req = 1'b0;
    wait_out(1'b1, 1'b1);
    chk("R6 minimum reset width", t_rr - t_rf, MIN_CLKS + 2);

    // R7: power-on request during a running power-off gap
    dly_pwr2rst = 8'd2; dly_rst2pwr = 8'd30;
    repeat (5) step();
    pwr_off_req = 1'b1;
    repeat (10) step();
    pwr_off_req = 1'b0;
    wait_out(1'b0, 1'b0);
    wait_out(1'b1, 1'b1);
    chk("R7 off gap completes", t_pf - t_rf, 30 * TC + 1);
    chk("R7 power-on waits for min width", t_pr - t_rf, MIN_CLKS + 1);
    chk("R7 then normal pwr-to-rst gap", t_rr - t_pr, 2 * TC + 1);

    // R10: abort during the power-on gap
    pwr_off_req = 1'b1;
    wait_out(1'b0, 1'b0);
    repeat (MIN_CLKS + 20) step();
    dly_pwr2rst = 8'd100; dly_rst2pwr = 8'd3;
    pwr_off_req = 1'b0;
    wait_out(1'b0, 1'b1);
    repeat (20) step();
    nr = n_rr;
    c = cyc;
    pwr_off_req = 1'b1;
    wait_out(1'b0, 1'b0);
    chk("R10 abort pwr fall timing", t_pf - c, 3 * TC + 2);
    chk("R10 reset never released", (n_rr == nr) && (slot_rst_n == 1'b0), 1);

    // R8: power-good controlled mode
    rst_mode = 1'b1;
    pgood_in = 1'b0;
    repeat (5) step();
    chk("R8 pwr_en off in pg mode", slot_pwr_en, 0);
    c = cyc;
    pwr_off_req = 1'b0;
    step();
    chk("R8 pwr_en follows request", t_pr - c, 1);
    c = cyc;
    pgood_in = 1'b1;
    repeat (PGOOD_SYNC + 1) step();
    chk("R8 rst_n rises after pgood", (slot_rst_n == 1'b1) && (t_rr - c == PGOOD_SYNC + 1), 1);
    c = cyc;
    pgood_in = 1'b0;
    wait_out(1'b1, 1'b0);
    chk("R8 rst_n falls after pgood loss", t_rf - c, PGOOD_SYNC + 1);
    pgood_in = 1'b1;
    wait_out(1'b1, 1'b1);
    chk("R6 min width in pg mode", t_rr - t_rf, MIN_CLKS + 1);
    pwr_off_req = 1'b1;
    step();
    chk("R8 pwr_en drops with request", slot_pwr_en, 0);

    chk("R2 no rst release while power off", order_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule